// File: doc/BRIEF.md
# Display Identification Reader over DDC

This block fetches display identification bytes from a monitor over a two-wire, I2C-style DDC bus on behalf of a host. The host sets a slave header, a start offset, a byte count and a segment number through a small byte-wide register file. It then writes a one-byte command. One opcode empties the receive FIFO. The other runs a complete bus read whose bytes land in a 32-entry receive FIFO, and the host drains that FIFO one byte per read of a data register.

The bit-level bus master is part of the block. It generates start, repeated start and stop conditions, shifts bytes out and in, and handles acknowledge bits. It waits while a slave stretches the clock, and it notices when another driver pulls the data line low against it. When the segment is nonzero, the segment pointer device at write header 0x60 is loaded first. A status register reports completion and three distinct error causes.

The bus pins are open-drain. Each `*_pull` output, when high, pulls the line low, and the `*_in` inputs see the resolved line level.

Top module: `ddc_edid_reader`

## Requirements
- R1: After reset the status register (0x16) reads 0x00, a read of the FIFO data register (0x17) returns 0x00, and both bus pull outputs are low.
- R2: Writes to the command register 0x15 are ignored while the host-ownership bit (bit 0 of register 0x10) is 0. The status value stays unchanged.
- R3: Command 0x09 empties the receive FIFO, clears the error bits and sets the done bit, so status reads 0x80.
- R4: Command 0x03 with segment 0 runs start, header, offset, repeated start, header with bit 0 set, the data bytes, and stop. Status then reads 0x80 and the FIFO holds the display bytes that begin at the offset.
- R5: With a nonzero segment (register 0x14), the master first writes the segment value to header 0x60 and then follows a repeated start with the sequence of R4. The bytes come from that segment.
- R6: The master acknowledges every received byte except the last. It gives the last byte a not-acknowledge followed by a stop, so the slave sends exactly the requested number of bytes.
- R7: A count (register 0x13) of 0 sets done with no bus activity. A count above 32 is treated as 32.
- R8: Each read of register 0x17 pops the oldest byte. A read of an empty FIFO returns 0x00. Bytes that arrive while the FIFO already holds 32 are discarded.
- R9: A not-acknowledge on any transmitted byte sets status bit 5 and is followed by a stop. The done bit stays clear.
- R10: Status bit 4 (bus wait) is set, without bus activity, when a read command finds either line low. It is also set when a slave stretches the clock longer than STRETCH_LIMIT cycles.
- R11: If the data line reads low while the master releases it to send a 1, status bit 3 is set and the master releases both lines at once.
- R12: While a slave holds the clock low, the master waits, and the transfer still completes with correct data.
- R13: Writing a read command clears done and the error bits. Command values other than 0x03 and 0x09 are ignored, and command writes made while a transfer runs are ignored.
- R14: Registers 0x10 (bit 0), 0x11, 0x12, 0x13 and 0x14 read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| scl_in | input | 1 | Resolved clock line level |
| sda_in | input | 1 | Resolved data line level |
| scl_pull | output | 1 | Pull clock line low when high |
| sda_pull | output | 1 | Pull data line low when high |

## Verification
The assertions take for granted that the host issues no command while it is also popping the FIFO. They also assume the bus lines stay quiet for the few cycles that a command needs to see them through the input synchronisers. The stimulus keeps to this by polling status until done or an error appears before it touches the FIFO or issues the next command. It also gives the bus several idle cycles after any injected fault before the next command. The bench slave answers only at addresses 0x60, 0xA0 and 0xA1, and it changes the data line only while the clock is low, except where a fault is injected on purpose.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam logic [7:0] A_OWNER  = 8'h10;
  localparam logic [7:0] A_HDR    = 8'h11;
  localparam logic [7:0] A_OFF    = 8'h12;
  localparam logic [7:0] A_CNT    = 8'h13;
  localparam logic [7:0] A_SEG    = 8'h14;
  localparam logic [7:0] A_CMD    = 8'h15;
  localparam logic [7:0] A_STAT   = 8'h16;
  localparam logic [7:0] A_FIFO   = 8'h17;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_CLR  = 8'h09;

  typedef enum logic [1:0] {BOP_START, BOP_STOP, BOP_BIT} bop_e;

  typedef enum logic [3:0] {
    STP_SEG_S, STP_SEG_A, STP_SEG_D, STP_H_S, STP_H_W,
    STP_OFF, STP_R_S, STP_H_R, STP_RX, STP_STOP
  } step_e;
endpackage

// File: rtl/ddc_rx_fifo.sv
module ddc_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] q
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; rptr <= '0; count <= '0; q <= '0;
    end else if (clr) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop) begin
        rptr <= rptr + 1'b1;
        q    <= mem[rptr];
      end else if (pop) begin
        q <= '0;
      end
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> (count == $past(count)));
  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
endmodule

// File: rtl/ddc_bit_engine.sv
module ddc_bit_engine
  import ddc_pkg::*;
#(
  parameter int QTR_CYC       = 625,
  parameter int STRETCH_LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  bop_e op,
  input  logic txb,
  input  logic chk,
  input  logic scl_s,
  input  logic sda_s,
  output logic busy,
  output logic done,
  output logic rxb,
  output logic arb,
  output logic tmo,
  output logic scl_oe,
  output logic sda_oe
);
  localparam int QW = $clog2(QTR_CYC + 1);
  localparam int SW = $clog2(STRETCH_LIMIT + 1);

  logic          active;
  logic [1:0]    q;
  logic [QW-1:0] cnt;
  logic [SW-1:0] st;
  bop_e          op_r;
  logic          txb_r, chk_r;

  assign busy = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; q <= '0; cnt <= '0; st <= '0;
      op_r <= BOP_BIT; txb_r <= 1'b1; chk_r <= 1'b0;
      done <= 1'b0; rxb <= 1'b0; arb <= 1'b0; tmo <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      done <= 1'b0; arb <= 1'b0; tmo <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1; q <= '0; cnt <= '0; st <= '0;
          op_r <= op; txb_r <= txb; chk_r <= chk;
          case (op)
            BOP_START: sda_oe <= 1'b0;
            BOP_STOP:  sda_oe <= 1'b1;
            default:   sda_oe <= !txb;
          endcase
        end
      end else if (q == 2'd1 && !scl_s) begin
        if (st == SW'(STRETCH_LIMIT)) begin
          tmo <= 1'b1; done <= 1'b1; active <= 1'b0;
          scl_oe <= 1'b0; sda_oe <= 1'b0;
        end else begin
          st <= st + 1'b1;
        end
      end else if (cnt != QW'(QTR_CYC - 1)) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        q   <= q + 1'b1;
        case (q)
          2'd0: scl_oe <= 1'b0;
          2'd1: begin
            case (op_r)
              BOP_START: sda_oe <= 1'b1;
              BOP_STOP:  sda_oe <= 1'b0;
              default: begin
                rxb <= sda_s;
                if (chk_r && txb_r && !sda_s) begin
                  arb <= 1'b1; done <= 1'b1; active <= 1'b0;
                  scl_oe <= 1'b0; sda_oe <= 1'b0;
                end
              end
            endcase
          end
          2'd2: if (op_r != BOP_STOP) scl_oe <= 1'b1;
          default: begin done <= 1'b1; active <= 1'b0; end
        endcase
      end
    end
  end

  assert_stretch_wait_R12: assert property (@(posedge clk) disable iff (rst)
    (active && q == 2'd1 && !scl_s) |=> (q == 2'd1 || !active));
  assert_arb_release_R11: assert property (@(posedge clk) disable iff (rst)
    arb |-> (!scl_oe && !sda_oe && done));
endmodule

// File: rtl/ddc_edid_reader.sv
module ddc_edid_reader
  import ddc_pkg::*;
#(
  parameter int         QTR_CYC       = 625,
  parameter int         STRETCH_LIMIT = 100000,
  parameter int         FIFO_DEPTH    = 32,
  parameter logic [7:0] SEG_HDR       = 8'h60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [1:0] scl_sy, sda_sy;
  logic       scl_s, sda_s;
  logic       owner;
  logic [7:0] hdr, off, cnt, seg;
  logic       st_done, st_nack, st_wait, st_arb;
  logic       run, issued, eng_go;
  step_e      step;
  logic [3:0] bidx;
  logic [CW-1:0] remaining, cnt_eff;
  logic [7:0] shreg, tx_byte, rd_reg, fifo_q;
  logic       rd_sel_fifo, fifo_push, fifo_clr;
  logic       cmd_ok, is_start, is_stop, is_rx, eng_txb, eng_chk;
  bop_e       eng_op;
  logic       eng_busy, eng_done, eng_rxb, eng_arb, eng_tmo;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11;
    end else begin
      scl_sy <= {scl_sy[0], scl_in}; sda_sy <= {sda_sy[0], sda_in};
    end
  end
  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  assign cmd_ok   = reg_wr && reg_addr == A_CMD && owner && !run;
  assign cnt_eff  = (cnt > 8'(FIFO_DEPTH)) ? CW'(FIFO_DEPTH) : CW'(cnt);
  assign is_start = (step == STP_SEG_S) || (step == STP_H_S) || (step == STP_R_S);
  assign is_stop  = (step == STP_STOP);
  assign is_rx    = (step == STP_RX);

  always_comb begin
    case (step)
      STP_SEG_A: tx_byte = SEG_HDR;
      STP_SEG_D: tx_byte = seg;
      STP_OFF:   tx_byte = off;
      STP_H_R:   tx_byte = hdr | 8'h01;
      default:   tx_byte = hdr;
    endcase
    eng_op = is_start ? BOP_START : (is_stop ? BOP_STOP : BOP_BIT);
    if (is_rx) eng_txb = (bidx == 4'd8) ? (remaining == CW'(1)) : 1'b1;
    else       eng_txb = (bidx == 4'd8) ? 1'b1 : tx_byte[3'd7 - bidx[2:0]];
    eng_chk = !is_rx && !is_start && !is_stop && (bidx != 4'd8);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner <= 1'b0; hdr <= '0; off <= '0; cnt <= '0; seg <= '0;
      st_done <= 1'b0; st_nack <= 1'b0; st_wait <= 1'b0; st_arb <= 1'b0;
      run <= 1'b0; issued <= 1'b0; eng_go <= 1'b0; step <= STP_H_S;
      bidx <= '0; remaining <= '0; shreg <= '0;
      fifo_push <= 1'b0; fifo_clr <= 1'b0;
    end else begin
      eng_go <= 1'b0; fifo_push <= 1'b0; fifo_clr <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          A_OWNER: owner <= reg_wdata[0];
          A_HDR:   hdr <= reg_wdata;
          A_OFF:   off <= reg_wdata;
          A_CNT:   cnt <= reg_wdata;
          A_SEG:   seg <= reg_wdata;
          default: ;
        endcase
      end
      if (cmd_ok && (reg_wdata == OPC_CLR || reg_wdata == OPC_READ)) begin
        st_nack <= 1'b0; st_wait <= 1'b0; st_arb <= 1'b0; st_done <= 1'b0;
        if (reg_wdata == OPC_CLR) begin
          fifo_clr <= 1'b1; st_done <= 1'b1;
        end else if (!scl_s || !sda_s) begin
          st_wait <= 1'b1;
        end else if (cnt_eff == '0) begin
          st_done <= 1'b1;
        end else begin
          run <= 1'b1; issued <= 1'b0; bidx <= '0; remaining <= cnt_eff;
          step <= (seg != 8'h00) ? STP_SEG_S : STP_H_S;
        end
      end
      if (run && !issued && !eng_busy) begin
        eng_go <= 1'b1; issued <= 1'b1;
      end
      if (run && eng_done) begin
        issued <= 1'b0;
        if (eng_arb) begin
          st_arb <= 1'b1; run <= 1'b0;
        end else if (eng_tmo) begin
          st_wait <= 1'b1; run <= 1'b0;
        end else if (is_start) begin
          step <= step_e'(step + 4'd1); bidx <= '0;
        end else if (is_stop) begin
          run <= 1'b0;
          if (!st_nack) st_done <= 1'b1;
        end else if (is_rx) begin
          if (bidx != 4'd8) begin
            shreg <= {shreg[6:0], eng_rxb}; bidx <= bidx + 1'b1;
          end else begin
            fifo_push <= 1'b1; remaining <= remaining - 1'b1; bidx <= '0;
            if (remaining == CW'(1)) step <= STP_STOP;
          end
        end else if (bidx != 4'd8) begin
          bidx <= bidx + 1'b1;
        end else if (eng_rxb) begin
          st_nack <= 1'b1; step <= STP_STOP;
        end else begin
          step <= step_e'(step + 4'd1); bidx <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg <= '0; rd_sel_fifo <= 1'b0;
    end else begin
      rd_sel_fifo <= reg_rd && reg_addr == A_FIFO;
      case (reg_addr)
        A_OWNER: rd_reg <= {7'b0, owner};
        A_HDR:   rd_reg <= hdr;
        A_OFF:   rd_reg <= off;
        A_CNT:   rd_reg <= cnt;
        A_SEG:   rd_reg <= seg;
        A_STAT:  rd_reg <= {st_done, 1'b0, st_nack, st_wait, st_arb, 3'b000};
        default: rd_reg <= '0;
      endcase
    end
  end
  assign reg_rdata = rd_sel_fifo ? fifo_q : rd_reg;

  ddc_bit_engine #(.QTR_CYC(QTR_CYC), .STRETCH_LIMIT(STRETCH_LIMIT)) u_eng (
    .clk(clk), .rst(rst), .go(eng_go), .op(eng_op), .txb(eng_txb), .chk(eng_chk),
    .scl_s(scl_s), .sda_s(sda_s), .busy(eng_busy), .done(eng_done), .rxb(eng_rxb),
    .arb(eng_arb), .tmo(eng_tmo), .scl_oe(scl_pull), .sda_oe(sda_pull)
  );

  ddc_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst(rst), .clr(fifo_clr), .push(fifo_push), .din(shreg),
    .pop(reg_rd && reg_addr == A_FIFO), .q(fifo_q)
  );

  assert_done_no_error_R9: assert property (@(posedge clk) disable iff (rst)
    st_done |-> !(st_nack || st_wait || st_arb));
  assert_idle_released_R11: assert property (@(posedge clk) disable iff (rst)
    (!run && !eng_busy) |-> (!scl_pull && !sda_pull));
  assert_cmd_clears_R13: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && reg_wdata == OPC_READ) |=> (!st_nack && !st_arb));
  assert_owner_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_CMD && !owner && !run) |=> !run);
endmodule

// File: tb/tb_ddc_edid_reader.sv
module tb_ddc_edid_reader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic scl_pull, sda_pull;
  logic s_scl_low = 1'b0, s_sda_low = 1'b0, arb_hold = 1'b0;
  wire scl_bus = !(scl_pull || s_scl_low);
  wire sda_bus = !(sda_pull || s_sda_low || arb_hold);

  int n_tests = 0, n_fail = 0;
  int n_start = 0, n_stop = 0, n_sent = 0, n_segwr = 0;
  int s_phase = 0, k = 0, nxt = 0, stretch_cyc = 0, st_left = 0;
  logic [7:0] sh = '0, txb = '0, sseg = '0, soff = '0, last_seg = '0;
  logic pscl = 1'b1, psda = 1'b1, mack = 1'b0;

  always #2 clk = ~clk;

  ddc_edid_reader #(.QTR_CYC(4), .STRETCH_LIMIT(200)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  function automatic logic [7:0] edid(input logic [7:0] s, input logic [7:0] o);
    return (s * 8'd37) ^ (o * 8'd3 + 8'h1B);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // bench slave: display data at 0xA0/0xA1, segment pointer at 0x60
  initial begin
    forever begin
      @(negedge clk);
      if (st_left > 0) st_left--;
      s_scl_low = (st_left > 0);
      if (pscl && scl_bus && psda && !sda_bus) begin
        n_start++; s_phase = 1; k = -1; s_sda_low = 1'b0;
      end else if (pscl && scl_bus && !psda && sda_bus) begin
        n_stop++; s_phase = 0; sseg = '0; s_sda_low = 1'b0;
      end else if (!pscl && scl_bus && s_phase != 0) begin
        if (s_phase == 4) begin
          if (k == 8) mack = !sda_bus;
        end else if (k >= 0 && k < 8) sh = {sh[6:0], sda_bus};
      end else if (pscl && !scl_bus && s_phase != 0) begin
        if (stretch_cyc > 0) begin st_left = stretch_cyc; s_scl_low = 1'b1; end
        if (s_phase == 4) begin
          if (k < 7) begin k++; s_sda_low = !txb[7-k]; end
          else if (k == 7) begin k = 8; s_sda_low = 1'b0; end
          else begin
            k = 0;
            if (mack) begin
              txb = edid(sseg, soff); soff++; n_sent++; s_sda_low = !txb[7];
            end else begin s_phase = 5; s_sda_low = 1'b0; end
          end
        end else if (s_phase != 5) begin
          if (k < 7) k++;
          else if (k == 7) begin
            k = 8;
            if (s_phase == 1) begin
              case (sh)
                8'h60: nxt = 2;
                8'hA0: nxt = 3;
                8'hA1: nxt = 4;
                default: nxt = -1;
              endcase
            end else nxt = 5;
            s_sda_low = (nxt != -1);
            if (nxt == -1) nxt = 5;
          end else begin
            k = 0; s_sda_low = 1'b0;
            if (s_phase == 2) begin sseg = sh; last_seg = sh; n_segwr++; end
            if (s_phase == 3) soff = sh;
            s_phase = nxt;
            if (nxt == 4) begin
              txb = edid(sseg, soff); soff++; n_sent++; s_sda_low = !txb[7];
            end
          end
        end
      end
      pscl = scl_bus; psda = sda_bus;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); d = reg_rdata; reg_rd = 1'b0;
  endtask

  task automatic wait_status(output logic [7:0] s);
    s = '0;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h16, s);
      if ((s & 8'hB8) != 0) break;
    end
  endtask

  task automatic do_read(input logic [7:0] sg, input logic [7:0] of, input logic [7:0] ct,
                         output logic [7:0] s);
    wr(8'h12, of); wr(8'h13, ct); wr(8'h14, sg); wr(8'h15, 8'h03);
    wait_status(s);
  endtask

  task automatic pop_check(input logic [7:0] sg, input logic [7:0] of, input int n, input string req);
    logic [7:0] d;
    int bad = 0;
    logic [7:0] a = 0, e = 0;
    for (int i = 0; i < n; i++) begin
      rd(8'h17, d);
      if (d !== edid(sg, of + 8'(i)) && bad == 0) begin bad = 1; a = d; e = edid(sg, of + 8'(i)); end
    end
    check(bad == 0, req, a, e);
  endtask

  initial begin
    logic [7:0] s, d;
    int b_sent, b_stop, b_seg, b_start;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1
    rd(8'h16, s); check(s == 8'h00, "R1 status", s, 0);
    rd(8'h17, d); check(d == 8'h00, "R1 fifo empty", d, 0);
    check(!scl_pull && !sda_pull, "R1 bus released", {scl_pull, sda_pull}, 0);
    // R14
    wr(8'h11, 8'hA0); rd(8'h11, d); check(d == 8'hA0, "R14 header", d, 8'hA0);
    wr(8'h12, 8'h5A); rd(8'h12, d); check(d == 8'h5A, "R14 offset", d, 8'h5A);
    wr(8'h14, 8'h03); rd(8'h14, d); check(d == 8'h03, "R14 segment", d, 8'h03);
    // R2
    wr(8'h15, 8'h09); rd(8'h16, s); check(s == 8'h00, "R2 not owner", s, 0);
    wr(8'h10, 8'h01); rd(8'h10, d); check(d == 8'h01, "R14 owner", d, 1);
    // R3
    wr(8'h15, 8'h09); rd(8'h16, s); check(s == 8'h80, "R3 clear done", s, 8'h80);
    // R4 / R6
    b_sent = n_sent; b_stop = n_stop; b_seg = n_segwr;
    do_read(8'h00, 8'h10, 8'd8, s);
    check(s == 8'h80, "R4 status", s, 8'h80);
    pop_check(8'h00, 8'h10, 8, "R4 data");
    check(n_sent - b_sent == 8, "R6 bytes sent", n_sent - b_sent, 8);
    check(n_stop - b_stop == 1, "R6 stop", n_stop - b_stop, 1);
    check(n_segwr == b_seg, "R4 no segment write", n_segwr - b_seg, 0);
    // R5
    wr(8'h15, 8'h09);
    do_read(8'h02, 8'h40, 8'd6, s);
    check(s == 8'h80 && n_segwr == b_seg + 1 && last_seg == 8'h02, "R5 segment write", last_seg, 2);
    pop_check(8'h02, 8'h40, 6, "R5 data");
    // R4 random
    void'($urandom(32'd1234));
    for (int t = 0; t < 4; t++) begin
      logic [7:0] sg, of, ct;
      sg = 8'($urandom % 3); of = 8'($urandom % 256); ct = 8'(1 + $urandom % 32);
      wr(8'h15, 8'h09);
      b_sent = n_sent;
      do_read(sg, of, ct, s);
      check(s == 8'h80, "R4 random status", s, 8'h80);
      check(n_sent - b_sent == int'(ct), "R6 random count", n_sent - b_sent, ct);
      pop_check(sg, of, int'(ct), "R4 random data");
    end
    // R7
    wr(8'h15, 8'h09); b_start = n_start;
    do_read(8'h00, 8'h00, 8'd0, s);
    check(s == 8'h80 && n_start == b_start, "R7 zero count", n_start - b_start, 0);
    b_sent = n_sent;
    do_read(8'h00, 8'h00, 8'd40, s);
    check(n_sent - b_sent == 32, "R7 clamp", n_sent - b_sent, 32);
    pop_check(8'h00, 8'h00, 32, "R7 clamp data");
    rd(8'h17, d); check(d == 8'h00, "R8 empty pop", d, 0);
    // R8 overflow
    wr(8'h15, 8'h09);
    do_read(8'h00, 8'h00, 8'd20, s);
    do_read(8'h00, 8'd20, 8'd20, s);
    pop_check(8'h00, 8'h00, 32, "R8 full fifo data");
    rd(8'h17, d); check(d == 8'h00, "R8 dropped bytes", d, 0);
    // R13 unknown opcode
    wr(8'h15, 8'h55); rd(8'h16, s); check(s == 8'h80, "R13 unknown opcode", s, 8'h80);
    // R9
    wr(8'h11, 8'hA4); b_stop = n_stop; b_sent = n_sent;
    do_read(8'h00, 8'h00, 8'd4, s);
    repeat (40) @(negedge clk);
    check(s == 8'h20, "R9 nack status", s, 8'h20);
    check(n_stop - b_stop == 1 && n_sent == b_sent, "R9 stop after nack", n_stop - b_stop, 1);
    wr(8'h11, 8'hA0);
    // R13 command clears error
    wr(8'h15, 8'h09);
    do_read(8'h00, 8'h00, 8'd2, s);
    check(s == 8'h80, "R13 error cleared", s, 8'h80);
    wr(8'h15, 8'h09);
    // R10 bus busy
    arb_hold = 1'b1; repeat (5) @(negedge clk);
    wr(8'h15, 8'h03); rd(8'h16, s);
    check(s == 8'h10, "R10 bus busy", s, 8'h10);
    arb_hold = 1'b0; repeat (10) @(negedge clk);
    // R12 stretch
    stretch_cyc = 20;
    do_read(8'h01, 8'h03, 8'd5, s);
    check(s == 8'h80, "R12 stretch status", s, 8'h80);
    pop_check(8'h01, 8'h03, 5, "R12 stretch data");
    // R10 stretch timeout
    stretch_cyc = 400;
    do_read(8'h00, 8'h00, 8'd3, s);
    check(s == 8'h10, "R10 stretch timeout", s, 8'h10);
    check(!scl_pull && !sda_pull, "R10 released", {scl_pull, sda_pull}, 0);
    stretch_cyc = 0; repeat (500) @(negedge clk);
    // R11 arbitration
    wr(8'h15, 8'h09);
    wr(8'h12, 8'hFF); wr(8'h13, 8'd4); wr(8'h14, 8'h00); wr(8'h15, 8'h03);
    for (int i = 0; i < 5000; i++) begin
      if (s_phase == 3 && !scl_bus) break;
      @(negedge clk);
    end
    arb_hold = 1'b1;
    wait_status(s);
    check(s == 8'h08, "R11 arbitration status", s, 8'h08);
    check(!scl_pull && !sda_pull, "R11 released", {scl_pull, sda_pull}, 0);
    arb_hold = 1'b0; repeat (10) @(negedge clk);
    // R13 command during transfer ignored
    wr(8'h15, 8'h09);
    wr(8'h12, 8'h08); wr(8'h13, 8'd4); wr(8'h15, 8'h03);
    wr(8'h15, 8'h09);
    wait_status(s);
    check(s == 8'h80, "R13 busy status", s, 8'h80);
    pop_check(8'h00, 8'h08, 4, "R13 busy clear ignored");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule